// File: doc/BRIEF.md
# Registered Four-Port Bus Exchanger

The block is a synchronous crossbar joining four bidirectional ports of `W` bits each (9 by default). Each pad appears as three signals: an input word, an output word and an output enable. The ports have fixed indices: 0 is 1A, 1 is 2A, 2 is 1B and 3 is 2B. A 5-bit select code picks one port as the source and a set of the other ports as destinations.

The clock edge does one of two jobs, chosen by a select-enable input. When select-enable is low, the edge stores the select code as the routing state and loads the output enables decoded from that code. When select-enable is high, the edge captures the current source port's input into a data register. Every enabled destination then drives that registered word.

An asynchronous preset drops every output enable at once and clears the routing state. The outputs stay disabled until an edge with both preset and select-enable low loads a new routing state. The enables come only from registers and never from the select pins, so they cannot glitch.

Top module: `quad_port_exchanger`

## Requirements
- R1: While reset is asserted, and after it is released, all four output enables are 0 and every output word is 0.
- R2: A rising edge with select-enable low loads the routing state. Bits [1:0] of the select code name the source port by index, where 0 is 1A, 1 is 2A, 2 is 1B and 3 is 2B. Port p occupies bits [p*W +: W] of the flat words and bit p of the enable vector.
- R3: Select bits [4:2] are a mask over the three non-source ports, taken in ascending port index: bit 2 enables the lowest of them and bit 4 the highest. A zero mask leaves all enables at 0.
- R4: The output enable of the source port is never set.
- R5: A rising edge with select-enable high captures the source port's input word. Every port's output word then carries that value, and the enables do not change.
- R6: On edges with select-enable low the data register holds its value. The outputs carry the registered word, not the live inputs.
- R7: Raising preset clears all output enables at once, with no clock edge.
- R8: Preset has priority over every clock action. After preset falls, the enables stay 0 through capture edges until an edge with preset and select-enable both low. While preset is high the routing state is cleared to source 0 with an empty mask.
- R9: Preset does not clear the data register. The register holds through edges that occur while preset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| preset | input | 1 | Asynchronous output disable, active high |
| sel_en | input | 1 | Low: load routing state; high: capture data |
| sel_code | input | 5 | [1:0] source index, [4:2] destination mask |
| port_in | input | 4*W | Pad input words, port p at [p*W +: W] |
| port_out | output | 4*W | Pad output words, all carrying the data register |
| port_oe | output | 4 | Per-port output enable, bit p for port p |

## Verification
Two actions can fall in the same cycle: a preset and a clock edge that would load a routing state or capture data. The bench holds preset high across an edge with select-enable low and a fresh select code, and judges that the enables remain 0. It then holds preset across an edge with select-enable high and changed inputs, and judges that the output word keeps its earlier value. After preset falls, a capture edge must leave the enables at 0. The next state-load edge must restore the decoded enables.

// File: rtl/qpx_pkg.sv
package qpx_pkg;

  localparam int unsigned NUM_PORTS = 4;
  localparam int unsigned SRC_BITS  = 2;
  localparam int unsigned MASK_BITS = NUM_PORTS - 1;
  localparam int unsigned CODE_BITS = SRC_BITS + MASK_BITS;

  typedef struct packed {
    logic [MASK_BITS-1:0] mask;
    logic [SRC_BITS-1:0]  src;
  } route_t;

  // Map the mask over non-source ports (ascending index) to per-port enables.
  function automatic logic [NUM_PORTS-1:0] oe_decode(input route_t r);
    logic [NUM_PORTS-1:0] en;
    logic [SRC_BITS-1:0]  slot;
    en   = '0;
    slot = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (SRC_BITS'(p) != r.src) begin
        en[p] = r.mask[slot];
        slot  = slot + 1'b1;
      end
    end
    return en;
  endfunction

endpackage

// File: rtl/qpx_reset_sync.sv
module qpx_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic arst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign arst_n = sync_q[STAGES-1];

endmodule

// File: rtl/qpx_route_state.sv
module qpx_route_state
  import qpx_pkg::*;
(
  input  logic                 clk,
  input  logic                 arst_n,
  input  logic                 preset,
  input  logic                 sel_en,
  input  route_t               sel_code,
  output route_t               route_q,
  output logic [NUM_PORTS-1:0] oe_q
);

  logic                 load_en;
  route_t               route_d;
  logic [NUM_PORTS-1:0] oe_d;

  assign load_en = !sel_en;

  always_comb begin
    route_d = route_q;
    oe_d    = oe_q;
    if (load_en) begin
      route_d = sel_code;
      oe_d    = oe_decode(sel_code);
    end
  end

  // Preset acts asynchronously and outranks every clocked update.
  always_ff @(posedge clk or negedge arst_n or posedge preset) begin
    if (!arst_n) begin
      route_q <= '0;
      oe_q    <= '0;
    end else if (preset) begin
      route_q <= '0;
      oe_q    <= '0;
    end else begin
      route_q <= route_d;
      oe_q    <= oe_d;
    end
  end

endmodule

// File: rtl/qpx_data_path.sv
module qpx_data_path
  import qpx_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  logic                   clk,
  input  logic                   arst_n,
  input  logic                   preset,
  input  logic                   cap_en,
  input  logic [SRC_BITS-1:0]    src,
  input  logic [NUM_PORTS*W-1:0] port_in,
  output logic [W-1:0]           data_q
);

  logic [W-1:0] lane [NUM_PORTS];
  logic [W-1:0] data_d;
  logic         take;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
    assign lane[p] = port_in[p*W +: W];
  end

  assign take = cap_en && !preset;

  always_comb begin
    data_d = data_q;
    if (take) begin
      data_d = lane[src];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      data_q <= '0;
    end else begin
      data_q <= data_d;
    end
  end

endmodule

// File: rtl/quad_port_exchanger.sv
module quad_port_exchanger
  import qpx_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   preset,
  input  logic                   sel_en,
  input  logic [CODE_BITS-1:0]   sel_code,
  input  logic [NUM_PORTS*W-1:0] port_in,
  output logic [NUM_PORTS*W-1:0] port_out,
  output logic [NUM_PORTS-1:0]   port_oe
);

  logic                 arst_n;
  route_t               route_q;
  logic [NUM_PORTS-1:0] oe_q;
  logic [W-1:0]         data_q;

  qpx_reset_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .arst_n (arst_n)
  );

  qpx_route_state u_route (
    .clk      (clk),
    .arst_n   (arst_n),
    .preset   (preset),
    .sel_en   (sel_en),
    .sel_code (route_t'(sel_code)),
    .route_q  (route_q),
    .oe_q     (oe_q)
  );

  qpx_data_path #(.W(W)) u_data (
    .clk     (clk),
    .arst_n  (arst_n),
    .preset  (preset),
    .cap_en  (sel_en),
    .src     (route_q.src),
    .port_in (port_in),
    .data_q  (data_q)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_drive
    assign port_out[p*W +: W] = data_q;
  end

  assign port_oe = oe_q;

endmodule

// File: rtl/qpx_checker.sv
module qpx_checker
  import qpx_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   preset,
  input logic                   sel_en,
  input logic [CODE_BITS-1:0]   sel_code,
  input logic [NUM_PORTS*W-1:0] port_out,
  input logic [NUM_PORTS-1:0]   port_oe
);

  assert_load_decode_R2: assert property (@(posedge clk) disable iff (!rst_n || preset)
    !sel_en |=> (port_oe == oe_decode(route_t'($past(sel_code)))));

  assert_empty_mask_R3: assert property (@(posedge clk) disable iff (!rst_n || preset)
    (!sel_en && sel_code[CODE_BITS-1:SRC_BITS] == '0) |=> (port_oe == '0));

  assert_source_off_R4: assert property (@(posedge clk) disable iff (!rst_n || preset)
    !sel_en |=> !port_oe[$past(sel_code[SRC_BITS-1:0])]);

  assert_capture_keeps_oe_R5: assert property (@(posedge clk) disable iff (!rst_n || preset)
    sel_en |=> $stable(port_oe));

  assert_load_holds_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_en |=> $stable(port_out));

  assert_preset_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    preset |-> (port_oe == '0));

  assert_preset_holds_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> $stable(port_out));

endmodule

bind quad_port_exchanger qpx_checker #(.W(W)) u_qpx_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .preset   (preset),
  .sel_en   (sel_en),
  .sel_code (sel_code),
  .port_out (port_out),
  .port_oe  (port_oe)
);

// File: tb/quad_port_exchanger_tb_top.sv
module quad_port_exchanger_tb_top;

  localparam int unsigned W          = 9;
  localparam int unsigned NP         = 4;
  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned NVEC       = 8;

  // Each entry: sel_code[8:4], expected enables[3:0].
  localparam logic [8:0] VEC [NVEC] = '{
    {5'b111_00, 4'b1110},
    {5'b101_01, 4'b1001},
    {5'b010_10, 4'b0010},
    {5'b111_11, 4'b0111},
    {5'b100_11, 4'b0100},
    {5'b000_00, 4'b0000},
    {5'b001_10, 4'b0001},
    {5'b110_01, 4'b1100}
  };

  logic            clk;
  logic            rst_n;
  logic            preset;
  logic            sel_en;
  logic [4:0]      sel_code;
  logic [NP*W-1:0] port_in;
  logic [NP*W-1:0] port_out;
  logic [NP-1:0]   port_oe;

  int unsigned n_run;
  int unsigned n_fail;
  logic [W-1:0] exp_data;

  quad_port_exchanger #(.W(W)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .preset   (preset),
    .sel_en   (sel_en),
    .sel_code (sel_code),
    .port_in  (port_in),
    .port_out (port_out),
    .port_oe  (port_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] word_of(input int k, input int p);
    return W'((k * 37 + p * 101 + 5) % 512);
  endfunction

  function automatic logic [NP*W-1:0] pattern(input int k);
    logic [NP*W-1:0] v;
    for (int p = 0; p < NP; p++) v[p*W +: W] = word_of(k, p);
    return v;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [NP*W-1:0] act, input logic [NP*W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [W-1:0] d);
    check(req, "port_out", port_out, {NP{d}});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run    = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    preset   = 1'b0;
    sel_en   = 1'b0;
    sel_code = '0;
    port_in  = '0;
    repeat (3) @(negedge clk);
    check("R1", "oe in reset", NP*W'(port_oe), '0);
    check_out("R1", '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "oe after reset", NP*W'(port_oe), '0);
    check_out("R1", '0);
    exp_data = '0;

    // Table walk: load state, then capture.
    for (int k = 0; k < NVEC; k++) begin
      sel_en   = 1'b0;
      sel_code = VEC[k][8:4];
      port_in  = pattern(k);
      @(negedge clk);
      check("R2/R3/R4", "oe after load", NP*W'(port_oe), NP*W'(VEC[k][3:0]));
      check_out("R6", exp_data);
      sel_en = 1'b1;
      @(negedge clk);
      exp_data = word_of(k, int'(VEC[k][5:4]));
      check_out("R5", exp_data);
      check("R5", "oe after capture", NP*W'(port_oe), NP*W'(VEC[k][3:0]));
    end

    // R6: load edges with new live inputs leave the output word alone.
    sel_en  = 1'b0;
    port_in = pattern(40);
    @(negedge clk);
    @(negedge clk);
    check_out("R6", exp_data);
    check("R6", "oe on reload", NP*W'(port_oe), NP*W'(4'b1100));

    // R7: preset mid-cycle, no clock edge needed.
    preset = 1'b1;
    #1;
    check("R7", "oe right after preset", NP*W'(port_oe), '0);
    // R8: a load edge while preset is high leaves enables off.
    sel_code = 5'b111_00;
    @(negedge clk);
    check("R8", "oe load during preset", NP*W'(port_oe), '0);
    // R9: capture edge while preset high holds data.
    sel_en  = 1'b1;
    port_in = pattern(50);
    @(negedge clk);
    check_out("R9", exp_data);
    // Preset falls; a capture edge must not re-enable outputs.
    preset = 1'b0;
    #1;
    check("R8", "oe after preset fall", NP*W'(port_oe), '0);
    check_out("R9", exp_data);
    @(negedge clk);
    check("R8", "oe after capture edge", NP*W'(port_oe), '0);
    exp_data = word_of(50, 0);
    check_out("R8", exp_data);
    // State-load edge with preset low brings enables back.
    sel_en   = 1'b0;
    sel_code = 5'b111_10;
    @(negedge clk);
    check("R8", "oe after state load", NP*W'(port_oe), NP*W'(4'b1011));
    sel_en = 1'b1;
    @(negedge clk);
    exp_data = word_of(50, 2);
    check_out("R5", exp_data);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule